// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 interrupt sources and delivers them to a processor on two outputs: a fast-interrupt line and a normal-interrupt line. Each source is the OR of a level-sensitive hardware request line and a software-settable request bit. A per-source enable mask gates the source, and a per-source route bit sends it to one output or the other. Enable bits and software request bits each have their own set and clear registers, so one bit can be changed with a single write and without a read-modify-write.

Sixteen prioritised vector slots each name one source and hold a handler address. Slot 0 has the highest priority. A handler reads the current-vector register to get the address of the most urgent pending normal-interrupt source. That read also marks the slot's priority as in service, so equal and lower priority slots stop pre-empting it. Writing any value to the same register ends service of the most urgent level and restores the one below it. When no slot qualifies, the read returns a programmable default address.

All registers sit on a word-aligned bus. A read returns its data in the same cycle as the request, and a write takes effect at the clock edge that ends the request.

Top module: `vec_intc`

## Requirements
- R1: After reset the enable, route, software request, protection, test-control, default-address and slot registers all read 0, the in-service state is empty, and both outputs stay low even with every hardware line high.
- R2: Offset 0x08 reads the OR of the hardware lines and the software request bits.
- R3: A write to 0x10 sets the enable bits that are 1 in the data, and a write to 0x14 clears them. Zero data bits change nothing. 0x10 reads the enable mask and 0x14 reads 0.
- R4: A write to 0x18 sets software request bits, and a write to 0x1C clears them, with the same rule for zero bits. A set bit asserts its source just as a hardware line would. 0x18 reads the bits and 0x1C reads 0.
- R5: At offset 0x0C, route bit 1 sends a source to the fast output and 0 sends it to the normal output. 0x00 reads raw & enable & ~route, and 0x04 reads raw & enable & route.
- R6: irq_o is the OR of the normal status word and fiq_o is the OR of the fast status word.
- R7: Slot i has its handler address at 0x100+4i (32 bits) and its control at 0x200+4i. In the control word, bit 5 enables the slot and bits 4:0 pick the source. Only those 6 bits are stored and read back.
- R8: A read of 0x30 returns the handler address of the lowest-numbered enabled slot whose source is set in the normal status word and whose number is below the current in-service level. Otherwise it returns the default address held at 0x34. Sources routed to the fast output never select a slot.
- R9: A read of 0x30 puts the returned level in service (slot i is level i, the default is level 16) only if that level is more urgent than the current one. Otherwise the in-service state is unchanged.
- R10: A write of any value to 0x30 ends service of the most urgent in-service level, which lets less urgent slots be returned again. A write with nothing in service has no effect.
- R11: The protection bit (0x20, bit 0) and the test-control bit (0x300, bit 0) are stored and read back.
- R12: The four words at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the identification code in bits 7:0. The vendor code is in bits 19:12 of the assembled code (default 0x0A141190, vendor 0x41). Writes to these words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| src_req | input | 32 | Level-sensitive hardware request lines |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
Enable, route and software request bits go wrong in ways the ports show at once. A bit in the wrong state changes the status reads, and irq_o and fiq_o, in the same cycle the faulty state exists. In-service state that is wrong shows up only at the next read of 0x30. There it returns the default address in place of a slot's address, or the reverse, or a lower slot that should have been masked. For this reason the bench nests claims, acknowledges them one at a time, and checks the vector read after each step.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VIC_NSRC  = 32;
  localparam int VIC_SRC_W = $clog2(VIC_NSRC);
  localparam int VIC_AW    = 12;

  typedef struct packed {
    logic                 en;
    logic [VIC_SRC_W-1:0] src;
  } vslot_t;

  localparam logic [VIC_AW-1:0] OFF_IRQ  = 12'h000;
  localparam logic [VIC_AW-1:0] OFF_FIQ  = 12'h004;
  localparam logic [VIC_AW-1:0] OFF_RAW  = 12'h008;
  localparam logic [VIC_AW-1:0] OFF_SEL  = 12'h00C;
  localparam logic [VIC_AW-1:0] OFF_EN   = 12'h010;
  localparam logic [VIC_AW-1:0] OFF_ENC  = 12'h014;
  localparam logic [VIC_AW-1:0] OFF_SW   = 12'h018;
  localparam logic [VIC_AW-1:0] OFF_SWC  = 12'h01C;
  localparam logic [VIC_AW-1:0] OFF_PROT = 12'h020;
  localparam logic [VIC_AW-1:0] OFF_VEC  = 12'h030;
  localparam logic [VIC_AW-1:0] OFF_DEF  = 12'h034;
  localparam logic [VIC_AW-1:0] OFF_TST  = 12'h300;
  localparam logic [3:0]        PG_VADDR = 4'h1;
  localparam logic [3:0]        PG_VCTL  = 4'h2;
  localparam logic [7:0]        PG_ID    = 8'hFE;
endpackage

// File: rtl/vic_src_gate.sv
module vic_src_gate #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_set_we,
  input  logic            en_clr_we,
  input  logic            sel_we,
  input  logic            sw_set_we,
  input  logic            sw_clr_we,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] lines,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] sw_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  logic [NSRC-1:0] en_d, sel_d, sw_d;
  logic            en_upd, sw_upd;

  assign en_upd = en_set_we | en_clr_we;
  assign sw_upd = sw_set_we | sw_clr_we;

  always_comb begin
    en_d = en_q;
    if (en_set_we) en_d = en_d | wdata;
    if (en_clr_we) en_d = en_d & ~wdata;
    sw_d = sw_q;
    if (sw_set_we) sw_d = sw_d | wdata;
    if (sw_clr_we) sw_d = sw_d & ~wdata;
    sel_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
      sw_q  <= '0;
    end else begin
      if (en_upd) en_q  <= en_d;
      if (sel_we) sel_q <= sel_d;
      if (sw_upd) sw_q  <= sw_d;
    end
  end

  assign raw      = lines | sw_q;
  assign irq_stat = raw & en_q & ~sel_q;
  assign fiq_stat = raw & en_q & sel_q;
endmodule

// File: rtl/vic_slot_bank.sv
module vic_slot_bank
  import vic_pkg::*;
#(
  parameter int NSLOT  = 16,
  parameter int DW     = 32,
  parameter int SLOT_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOT_W-1:0]         idx,
  input  logic                      addr_we,
  input  logic                      ctrl_we,
  input  logic [DW-1:0]             wdata,
  output logic [NSLOT-1:0][DW-1:0]  addr_q,
  output vslot_t [NSLOT-1:0]        ctrl_q
);
  localparam int CW = VIC_SRC_W + 1;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic          hit, a_upd, c_upd;
    logic [DW-1:0] a_r, a_d;
    vslot_t        c_r, c_d;

    assign hit   = (idx == SLOT_W'(g));
    assign a_upd = addr_we & hit;
    assign c_upd = ctrl_we & hit;
    assign a_d   = wdata;
    assign c_d   = vslot_t'(wdata[CW-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r <= '0;
        c_r <= '0;
      end else begin
        if (a_upd) a_r <= a_d;
        if (c_upd) c_r <= c_d;
      end
    end

    assign addr_q[g] = a_r;
    assign ctrl_q[g] = c_r;
  end
endmodule

// File: rtl/vic_vec_arb.sv
module vic_vec_arb
  import vic_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int NSRC  = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          irq_stat,
  input  logic [NSLOT-1:0][DW-1:0] slot_addr,
  input  vslot_t [NSLOT-1:0]       slot_ctrl,
  input  logic [DW-1:0]            def_addr,
  input  logic                     claim,
  input  logic                     ack,
  output logic [DW-1:0]            vec_addr,
  output logic [NSLOT:0]           isr_mask
);
  localparam int LW     = $clog2(NSLOT + 2);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int MW     = NSLOT + 1;

  logic [LW-1:0]     cur_lvl, pick_lvl;
  logic [SLOT_W-1:0] pick_idx;
  logic              found, mask_upd;
  logic [MW-1:0]     mask_d, push_bit;

  // Most urgent level in service; NSLOT+1 means idle.
  always_comb begin
    cur_lvl = LW'(NSLOT + 1);
    for (int i = NSLOT; i >= 0; i--) begin
      if (isr_mask[i]) cur_lvl = LW'(i);
    end
  end

  // Lowest-numbered qualifying slot wins: scan downwards, last hit stays.
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_ctrl[i].en && irq_stat[slot_ctrl[i].src] && (LW'(i) < cur_lvl)) begin
        found    = 1'b1;
        pick_idx = SLOT_W'(i);
      end
    end
  end

  assign pick_lvl = found ? LW'(pick_idx) : LW'(NSLOT);
  assign vec_addr = found ? slot_addr[pick_idx] : def_addr;
  assign push_bit = MW'(1) << pick_lvl;
  assign mask_upd = ack | claim;

  always_comb begin
    mask_d = isr_mask;
    if (ack)                               mask_d = isr_mask & (isr_mask - 1'b1);
    else if (claim && (pick_lvl < cur_lvl)) mask_d = isr_mask | push_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        isr_mask <= '0;
    else if (mask_upd) isr_mask <= mask_d;
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int          NSLOT   = 16,
  parameter int          DW      = 32,
  parameter logic [31:0] ID_CODE = 32'h0A14_1190
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [VIC_AW-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  input  logic [VIC_NSRC-1:0]   src_req,
  output logic                  irq_o,
  output logic                  fiq_o
);
  localparam int         NSRC   = VIC_NSRC;
  localparam int         SLOT_W = $clog2(NSLOT);
  localparam logic [5:0] NSLOT6 = 6'(NSLOT);

  logic rd_en, wr_en;
  logic en_set_we, en_clr_we, sel_we, sw_set_we, sw_clr_we;
  logic prot_we, tst_we, def_we, vaddr_we, vctl_we, vec_claim, vec_ack;
  logic hit_vaddr, hit_vctl, hit_id;
  logic [5:0]        slot_off;
  logic [SLOT_W-1:0] slot_idx;

  logic [NSRC-1:0] en_q, sel_q, sw_q, raw, irq_stat, fiq_stat;
  logic [NSLOT-1:0][DW-1:0] slot_addr;
  vslot_t [NSLOT-1:0]       slot_ctrl;
  logic [DW-1:0]   vec_addr, def_q, def_d, rdata_c;
  logic [NSLOT:0]  isr_mask;
  logic            prot_q, prot_d, tst_q, tst_d;
  logic [7:0]      id_byte;

  assign rd_en = bus_sel & ~bus_wr;
  assign wr_en = bus_sel &  bus_wr;

  assign slot_off  = bus_addr[7:2];
  assign slot_idx  = slot_off[SLOT_W-1:0];
  assign hit_vaddr = (bus_addr[11:8] == PG_VADDR) && (bus_addr[1:0] == 2'b00) && (slot_off < NSLOT6);
  assign hit_vctl  = (bus_addr[11:8] == PG_VCTL)  && (bus_addr[1:0] == 2'b00) && (slot_off < NSLOT6);
  assign hit_id    = (bus_addr[11:4] == PG_ID)    && (bus_addr[1:0] == 2'b00);

  assign en_set_we = wr_en && (bus_addr == OFF_EN);
  assign en_clr_we = wr_en && (bus_addr == OFF_ENC);
  assign sel_we    = wr_en && (bus_addr == OFF_SEL);
  assign sw_set_we = wr_en && (bus_addr == OFF_SW);
  assign sw_clr_we = wr_en && (bus_addr == OFF_SWC);
  assign prot_we   = wr_en && (bus_addr == OFF_PROT);
  assign tst_we    = wr_en && (bus_addr == OFF_TST);
  assign def_we    = wr_en && (bus_addr == OFF_DEF);
  assign vaddr_we  = wr_en && hit_vaddr;
  assign vctl_we   = wr_en && hit_vctl;
  assign vec_claim = rd_en && (bus_addr == OFF_VEC);
  assign vec_ack   = wr_en && (bus_addr == OFF_VEC);

  vic_src_gate #(.NSRC(NSRC)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_set_we (en_set_we),
    .en_clr_we (en_clr_we),
    .sel_we    (sel_we),
    .sw_set_we (sw_set_we),
    .sw_clr_we (sw_clr_we),
    .wdata     (bus_wdata[NSRC-1:0]),
    .lines     (src_req),
    .en_q      (en_q),
    .sel_q     (sel_q),
    .sw_q      (sw_q),
    .raw       (raw),
    .irq_stat  (irq_stat),
    .fiq_stat  (fiq_stat)
  );

  vic_slot_bank #(.NSLOT(NSLOT), .DW(DW), .SLOT_W(SLOT_W)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (slot_idx),
    .addr_we (vaddr_we),
    .ctrl_we (vctl_we),
    .wdata   (bus_wdata),
    .addr_q  (slot_addr),
    .ctrl_q  (slot_ctrl)
  );

  vic_vec_arb #(.NSLOT(NSLOT), .NSRC(NSRC), .DW(DW)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_stat  (irq_stat),
    .slot_addr (slot_addr),
    .slot_ctrl (slot_ctrl),
    .def_addr  (def_q),
    .claim     (vec_claim),
    .ack       (vec_ack),
    .vec_addr  (vec_addr),
    .isr_mask  (isr_mask)
  );

  // Small stored registers: next state, then register with enables.
  assign prot_d = bus_wdata[0];
  assign tst_d  = bus_wdata[0];
  assign def_d  = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      tst_q  <= 1'b0;
      def_q  <= '0;
    end else begin
      if (prot_we) prot_q <= prot_d;
      if (tst_we)  tst_q  <= tst_d;
      if (def_we)  def_q  <= def_d;
    end
  end

  assign id_byte = 8'(ID_CODE >> {bus_addr[3:2], 3'b000});

  always_comb begin
    rdata_c = '0;
    case (bus_addr)
      OFF_IRQ:  rdata_c = DW'(irq_stat);
      OFF_FIQ:  rdata_c = DW'(fiq_stat);
      OFF_RAW:  rdata_c = DW'(raw);
      OFF_SEL:  rdata_c = DW'(sel_q);
      OFF_EN:   rdata_c = DW'(en_q);
      OFF_SW:   rdata_c = DW'(sw_q);
      OFF_PROT: rdata_c = DW'(prot_q);
      OFF_VEC:  rdata_c = vec_addr;
      OFF_DEF:  rdata_c = def_q;
      OFF_TST:  rdata_c = DW'(tst_q);
      default: begin
        if (hit_vaddr)     rdata_c = slot_addr[slot_idx];
        else if (hit_vctl) rdata_c = DW'(slot_ctrl[slot_idx]);
        else if (hit_id)   rdata_c = DW'(id_byte);
      end
    endcase
  end

  assign bus_rdata = rd_en ? rdata_c : '0;
  assign irq_o     = |irq_stat;
  assign fiq_o     = |fiq_stat;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_set_we,
  input logic            en_clr_we,
  input logic            sw_set_we,
  input logic            sw_clr_we,
  input logic [NSRC-1:0] wdata,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] sw_q,
  input logic            vec_claim,
  input logic            vec_ack,
  input logic [NSLOT:0]  isr_mask,
  input logic            irq_o,
  input logic            fiq_o
);
  a_r3_en_set: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we |=> ((en_q & $past(wdata)) == $past(wdata)));

  a_r3_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we |=> ((en_q & $past(wdata)) == '0));

  a_r4_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_we |=> ((sw_q & $past(wdata)) == $past(wdata)));

  a_r4_sw_clr: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_we |=> ((sw_q & $past(wdata)) == '0));

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_o && !fiq_o));

  a_r9_push_one: assert property (@(posedge clk) disable iff (!rst_n)
    vec_claim |=> (($countones(isr_mask) >= $countones($past(isr_mask))) &&
                   ($countones(isr_mask) <= $countones($past(isr_mask)) + 1)));

  a_r10_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && (isr_mask != '0)) |=> ($countones(isr_mask) == $countones($past(isr_mask)) - 1));

  a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && (isr_mask == '0)) |=> (isr_mask == '0));
endmodule

bind vec_intc vic_chk #(.NSRC(NSRC), .NSLOT(NSLOT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_set_we (en_set_we),
  .en_clr_we (en_clr_we),
  .sw_set_we (sw_set_we),
  .sw_clr_we (sw_clr_we),
  .wdata     (bus_wdata[NSRC-1:0]),
  .en_q      (en_q),
  .sw_q      (sw_q),
  .vec_claim (vec_claim),
  .vec_ack   (vec_ack),
  .isr_mask  (isr_mask),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o)
);

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, src_req;
  logic        irq_o, fiq_o;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  vec_intc u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_req(src_req), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] ln;
    logic [31:0] x;
    logic [7:0]  req;
  } row_t;

  localparam int NROW = 26;
  localparam row_t TBL [NROW] = '{
    '{1'b1, 12'h010, 32'h0000_00F0, 32'h0, 32'h0,        8'd3},  // R3 set
    '{1'b0, 12'h010, 32'h0,         32'h0, 32'h0000_00F0, 8'd3},
    '{1'b1, 12'h014, 32'h0000_0030, 32'h0, 32'h0,        8'd3},  // R3 clear
    '{1'b0, 12'h010, 32'h0,         32'h0, 32'h0000_00C0, 8'd3},
    '{1'b0, 12'h014, 32'h0,         32'h0, 32'h0,        8'd3},
    '{1'b1, 12'h018, 32'h0000_0041, 32'h0, 32'h0,        8'd4},  // R4 set
    '{1'b0, 12'h018, 32'h0,         32'h0, 32'h0000_0041, 8'd4},
    '{1'b0, 12'h008, 32'h0, 32'h0000_0100, 32'h0000_0141, 8'd2}, // R2 raw
    '{1'b0, 12'h000, 32'h0, 32'h0000_0080, 32'h0000_00C0, 8'd5}, // R5 irq status
    '{1'b1, 12'h00C, 32'h0000_0080, 32'h0, 32'h0,        8'd5},
    '{1'b0, 12'h00C, 32'h0,         32'h0, 32'h0000_0080, 8'd5},
    '{1'b0, 12'h004, 32'h0, 32'h0000_0080, 32'h0000_0080, 8'd5}, // R5 fiq status
    '{1'b0, 12'h000, 32'h0, 32'h0000_0080, 32'h0000_0040, 8'd5},
    '{1'b1, 12'h01C, 32'h0000_0001, 32'h0, 32'h0,        8'd4},  // R4 clear
    '{1'b0, 12'h018, 32'h0,         32'h0, 32'h0000_0040, 8'd4},
    '{1'b0, 12'h01C, 32'h0,         32'h0, 32'h0,        8'd4},
    '{1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0, 32'h0,        8'd11}, // R11 protect
    '{1'b0, 12'h020, 32'h0,         32'h0, 32'h0000_0001, 8'd11},
    '{1'b1, 12'h300, 32'h0000_0001, 32'h0, 32'h0,        8'd11}, // R11 test
    '{1'b0, 12'h300, 32'h0,         32'h0, 32'h0000_0001, 8'd11},
    '{1'b0, 12'hFE0, 32'h0,         32'h0, 32'h0000_0090, 8'd12}, // R12 id
    '{1'b0, 12'hFE4, 32'h0,         32'h0, 32'h0000_0011, 8'd12},
    '{1'b0, 12'hFE8, 32'h0,         32'h0, 32'h0000_0014, 8'd12},
    '{1'b0, 12'hFEC, 32'h0,         32'h0, 32'h0000_000A, 8'd12},
    '{1'b1, 12'hFE0, 32'h0000_00FF, 32'h0, 32'h0,        8'd12},
    '{1'b0, 12'hFE0, 32'h0,         32'h0, 32'h0000_0090, 8'd12}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdchk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
    chk(tag, v, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; src_req = '0;
    do_reset();

    for (int i = 0; i < NROW; i++) begin
      src_req = TBL[i].ln;
      if (TBL[i].wr) wr(TBL[i].a, TBL[i].d);
      else rdchk(TBL[i].a, TBL[i].x, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // R6: outputs follow status words (en C0, route 80, soft 40)
    src_req = '0; #1;
    chk("R6 irq_o from soft bit", {31'b0, irq_o}, 32'd1);
    chk("R6 fiq_o idle", {31'b0, fiq_o}, 32'd0);
    src_req = 32'h80; #1;
    chk("R6 fiq_o from routed line", {31'b0, fiq_o}, 32'd1);
    src_req = '0;
    wr(12'h01C, 32'h40);
    chk("R4 clearing soft bit drops irq_o", {31'b0, irq_o}, 32'd0);

    // R1: reset state
    do_reset();
    src_req = 32'hFFFF_FFFF; #1;
    chk("R1 irq_o after reset", {31'b0, irq_o}, 32'd0);
    chk("R1 fiq_o after reset", {31'b0, fiq_o}, 32'd0);
    rdchk(12'h010, 32'h0, "R1 enable");
    rdchk(12'h00C, 32'h0, "R1 route");
    rdchk(12'h018, 32'h0, "R1 soft");
    rdchk(12'h020, 32'h0, "R1 protect");
    rdchk(12'h300, 32'h0, "R1 test");
    rdchk(12'h034, 32'h0, "R1 default");
    rdchk(12'h200, 32'h0, "R1 slot ctrl");
    src_req = '0;

    // Vector slots
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h034, 32'h0000_DEF0);
    wr(12'h100, 32'h0000_1000); wr(12'h200, 32'h25);        // slot0 src5
    wr(12'h104, 32'h0000_1100); wr(12'h204, 32'h23);        // slot1 src3
    wr(12'h108, 32'h0000_1200); wr(12'h208, 32'h03);        // slot2 off
    wr(12'h10C, 32'h0000_1300); wr(12'h20C, 32'hFFFF_FFE9); // slot3 src9
    rdchk(12'h204, 32'h23, "R7 ctrl readback");
    rdchk(12'h108, 32'h1200, "R7 addr readback");
    rdchk(12'h20C, 32'h29, "R7 ctrl keeps 6 bits");

    src_req = 32'h8;
    rdchk(12'h030, 32'h1100, "R8 single pending");
    src_req = 32'h28;
    rdchk(12'h030, 32'h1000, "R8 nested preempt");
    rdchk(12'h030, 32'hDEF0, "R9 nothing above level 0");
    wr(12'h030, 32'h0);
    rdchk(12'h030, 32'h1000, "R10 pop restores level 1");
    wr(12'h030, 32'h0); wr(12'h030, 32'h0);
    wr(12'h030, 32'h0); // R10 pop on empty
    src_req = 32'h200;
    rdchk(12'h030, 32'h1300, "R10 empty pop harmless");
    wr(12'h030, 32'h0);

    wr(12'h00C, 32'h200);
    #1;
    chk("R6 fiq_o routed", {31'b0, fiq_o}, 32'd1);
    chk("R6 irq_o off when routed", {31'b0, irq_o}, 32'd0);
    rdchk(12'h030, 32'hDEF0, "R8 fast source not vectored");
    wr(12'h00C, 32'h0);
    rdchk(12'h030, 32'h1300, "R9 slot preempts default level");
    wr(12'h030, 32'h0);
    rdchk(12'h030, 32'h1300, "R10 back at default level");
    finish_run();
  end
endmodule